// File: doc/BRIEF.md
# DMA Channel Interrupt Enable and Pending Bank

This block gathers completion events from a group of DMA channels and turns them into one level interrupt. Every channel owns a four-bit slot that records three kinds of event: half of a package moved, a whole package moved, and the channel's queue drained. Eight slots are packed into each 32-bit word, so sixteen channels need two enable words and two pending words. A one-cycle pulse on an event input latches the matching pending bit. Software clears pending bits by writing ones to them. The interrupt output stays high while any pending bit has its enable bit set.

Software reaches the bank over a plain register bus with separate write and read strobes and a byte address. Read data is registered and appears in the cycle after the read strobe. A read-only global word reports which channels are busy, taken from a busy vector that the channels drive.

Top module: `dmairq_bank`

## Requirements
- R1: After reset, all enable and pending bits are zero, the interrupt output is low and the read data is zero.
- R2: Enable word n sits at byte offset 4*n (0x00, 0x04). Channel c maps to word c/8 and slot c%8. The slot occupies bits [4*(c%8)+2 : 4*(c%8)]. A written value reads back unchanged in those bits.
- R3: Bit 3 of every slot is reserved. It reads as zero in both enable and pending words, and writes and events leave it zero.
- R4: A pulse on the half-package, package-done or queue-done input of channel c sets slot bit 0, 1 or 2 respectively in pending word c/8, whatever the enable setting. Pending word n sits at byte offset 0x10 + 4*n.
- R5: A write to a pending word clears exactly the bits that are one in the written value. All other pending bits keep their value.
- R6: When an event and a write-one-to-clear hit the same pending bit in the same cycle, the bit stays set.
- R7: The interrupt output is the OR, over both words, of each pending bit ANDed with its enable bit. It follows the registers in the same cycle and stays high for as long as that condition holds.
- R8: With both enable words at zero, the interrupt output is low even when pending bits are set.
- R9: A read of offset 0x30 returns the channel busy vector in bits [15:0] and zeros above. Writes to 0x30 change no register.
- R10: The value for a read appears on the read data in the cycle after the read strobe. Unmapped offsets read as zero.
- R11: While the read strobe is low, the read data holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| evt_half | input | 16 | Per-channel half-package event pulses |
| evt_pkg | input | 16 | Per-channel package-done event pulses |
| evt_queue | input | 16 | Per-channel queue-done event pulses |
| ch_busy | input | 16 | Per-channel busy flags |
| irq | output | 1 | Combined level interrupt |

## Verification
The bench builds the bank with its default parameters: sixteen channels, eight per word, four-bit slots and registered read data. Under these values both words are present, so the channel-to-word split at channel 8 and the top slot of each word (channels 7 and 15) are exercised. The registered read variant makes the one-cycle read latency and the hold behaviour observable. The busy vector fills the low half of the global word exactly, so the zero upper half can be checked.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
   // byte offsets of the register groups
   localparam int unsigned EN_BASE    = 'h00;
   localparam int unsigned PEND_BASE  = 'h10;
   localparam int unsigned GLB_OFS    = 'h30;
   localparam int unsigned WORD_BYTES = 4;

   // event kinds recorded in each slot, in slot-bit order
   localparam int unsigned EVT_HALF   = 0;
   localparam int unsigned EVT_PKG    = 1;
   localparam int unsigned EVT_QUEUE  = 2;
   localparam int unsigned EVT_KINDS  = 3;

   function automatic int unsigned en_offset(int unsigned idx);
      return EN_BASE + idx * WORD_BYTES;
   endfunction

   function automatic int unsigned pend_offset(int unsigned idx);
      return PEND_BASE + idx * WORD_BYTES;
   endfunction
endpackage

// File: rtl/dmairq_word.sv
module dmairq_word
   import dmairq_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned CH_PER_REG = 8,
   parameter int unsigned SLOT_W     = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             en_we,
   input  logic                             pend_we,
   input  logic [DATA_W-1:0]                wdata,
   input  logic [CH_PER_REG*EVT_KINDS-1:0]  evt,
   output logic [DATA_W-1:0]                en_q,
   output logic [DATA_W-1:0]                pend_q,
   output logic                             irq_req
);
   localparam int unsigned USED_W = CH_PER_REG * SLOT_W;

   logic [DATA_W-1:0] live_mask;
   logic [DATA_W-1:0] evt_spread;
   logic [DATA_W-1:0] clr_mask;
   logic [DATA_W-1:0] en_r;
   logic [DATA_W-1:0] pend_r;

   // lay out which bits hold state and where each event lands
   for (genvar c = 0; c < CH_PER_REG; c++) begin : g_slot
      for (genvar b = 0; b < SLOT_W; b++) begin : g_bit
         if (b < EVT_KINDS) begin : g_live
            assign live_mask[c*SLOT_W+b]  = 1'b1;
            assign evt_spread[c*SLOT_W+b] = evt[c*EVT_KINDS+b];
         end else begin : g_rsvd
            assign live_mask[c*SLOT_W+b]  = 1'b0;
            assign evt_spread[c*SLOT_W+b] = 1'b0;
         end
      end
   end

   if (USED_W < DATA_W) begin : g_pad
      assign live_mask[DATA_W-1:USED_W]  = '0;
      assign evt_spread[DATA_W-1:USED_W] = '0;
   end

   assign clr_mask = pend_we ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_r   <= '0;
         pend_r <= '0;
      end else begin
         if (en_we) begin
            en_r <= wdata & live_mask;
         end
         // a fresh event wins over a clear of the same bit
         pend_r <= ((pend_r & ~clr_mask) | evt_spread) & live_mask;
      end
   end

   assign en_q    = en_r;
   assign pend_q  = pend_r;
   assign irq_req = |(en_r & pend_r);

   // per-bit checks on the pending and enable state
   for (genvar c = 0; c < CH_PER_REG; c++) begin : g_chk
      for (genvar e = 0; e < EVT_KINDS; e++) begin : g_evt
         // R4
         evt_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt[c*EVT_KINDS+e] |=> pend_r[c*SLOT_W+e]);
         // R5
         w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_we && wdata[c*SLOT_W+e] && !evt[c*EVT_KINDS+e]) |=> !pend_r[c*SLOT_W+e]);
         // R4
         no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!pend_r[c*SLOT_W+e] && !evt[c*EVT_KINDS+e]) |=> !pend_r[c*SLOT_W+e]);
      end
   end

   // R2
   en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_we |=> $stable(en_r));
endmodule

// File: rtl/dmairq_rdport.sv
module dmairq_rdport
   import dmairq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_REGS  = 2,
   parameter int unsigned NUM_CH    = 16,
   parameter bit          REG_RDATA = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       rd_en,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [NUM_REGS*DATA_W-1:0] en_words,
   input  logic [NUM_REGS*DATA_W-1:0] pend_words,
   input  logic [NUM_CH-1:0]          busy,
   output logic [DATA_W-1:0]          rdata
);
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (addr == ADDR_W'(en_offset(i))) begin
            rd_mux = en_words[i*DATA_W +: DATA_W];
         end
         if (addr == ADDR_W'(pend_offset(i))) begin
            rd_mux = pend_words[i*DATA_W +: DATA_W];
         end
      end
      if (addr == ADDR_W'(GLB_OFS)) begin
         rd_mux = DATA_W'(busy);
      end
   end

   if (REG_RDATA) begin : g_flop
      logic [DATA_W-1:0] rdata_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rdata_r <= '0;
         end else if (rd_en) begin
            rdata_r <= rd_mux;
         end
      end
      assign rdata = rdata_r;

      // R11
      rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_en |=> $stable(rdata));
      // R9
      glb_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && addr == ADDR_W'(GLB_OFS)) |=> rdata == DATA_W'($past(busy)));
   end else begin : g_comb
      assign rdata = rd_mux;
   end
endmodule

// File: rtl/dmairq_bank.sv
module dmairq_bank
   import dmairq_pkg::*;
#(
   parameter int unsigned NUM_CH     = 16,
   parameter int unsigned CH_PER_REG = 8,
   parameter int unsigned SLOT_W     = 4,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 8,
   parameter bit          REG_RDATA  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [NUM_CH-1:0] evt_half,
   input  logic [NUM_CH-1:0] evt_pkg,
   input  logic [NUM_CH-1:0] evt_queue,
   input  logic [NUM_CH-1:0] ch_busy,
   output logic              irq
);
   localparam int unsigned NUM_REGS = NUM_CH / CH_PER_REG;
   localparam int unsigned EVW      = CH_PER_REG * EVT_KINDS;

   // elaboration-time parameter checks
   if (NUM_CH % CH_PER_REG != 0) begin : g_bad_split
      $error("channel count must be a multiple of channels per word");
   end
   if (SLOT_W < EVT_KINDS) begin : g_bad_slot
      $error("slot too narrow for the event kinds");
   end
   if (CH_PER_REG * SLOT_W > DATA_W) begin : g_bad_pack
      $error("slots do not fit in a data word");
   end
   if (NUM_CH > DATA_W) begin : g_bad_busy
      $error("busy vector wider than a data word");
   end
   if ((1 << ADDR_W) <= GLB_OFS) begin : g_bad_addr
      $error("address too narrow for the register map");
   end

   logic [NUM_REGS*DATA_W-1:0] en_words;
   logic [NUM_REGS*DATA_W-1:0] pend_words;
   logic [NUM_REGS-1:0]        irq_req;

   for (genvar w = 0; w < NUM_REGS; w++) begin : g_word
      logic            en_we;
      logic            pend_we;
      logic [EVW-1:0]  evt_w;

      assign en_we   = wr_en && (addr == ADDR_W'(en_offset(w)));
      assign pend_we = wr_en && (addr == ADDR_W'(pend_offset(w)));

      for (genvar c = 0; c < CH_PER_REG; c++) begin : g_ch
         assign evt_w[c*EVT_KINDS+EVT_HALF]  = evt_half[w*CH_PER_REG+c];
         assign evt_w[c*EVT_KINDS+EVT_PKG]   = evt_pkg[w*CH_PER_REG+c];
         assign evt_w[c*EVT_KINDS+EVT_QUEUE] = evt_queue[w*CH_PER_REG+c];
      end

      dmairq_word #(
         .DATA_W     (DATA_W),
         .CH_PER_REG (CH_PER_REG),
         .SLOT_W     (SLOT_W)
      ) u_word (
         .clk     (clk),
         .rst_n   (rst_n),
         .en_we   (en_we),
         .pend_we (pend_we),
         .wdata   (wdata),
         .evt     (evt_w),
         .en_q    (en_words[w*DATA_W +: DATA_W]),
         .pend_q  (pend_words[w*DATA_W +: DATA_W]),
         .irq_req (irq_req[w])
      );
   end

   assign irq = |irq_req;

   dmairq_rdport #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .NUM_REGS  (NUM_REGS),
      .NUM_CH    (NUM_CH),
      .REG_RDATA (REG_RDATA)
   ) u_rdport (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_en      (rd_en),
      .addr       (addr),
      .en_words   (en_words),
      .pend_words (pend_words),
      .busy       (ch_busy),
      .rdata      (rdata)
   );

   // R8
   mask_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_words == '0) |-> !irq);
   // R7
   irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (pend_words != '0));
   // R9
   glb_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(GLB_OFS)) |=> $stable(en_words));
endmodule

// File: tb/dmairq_bank_test.sv
module dmairq_bank_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [15:0] evt_half = '0;
   logic [15:0] evt_pkg = '0;
   logic [15:0] evt_queue = '0;
   logic [15:0] ch_busy = '0;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   dmairq_bank uut (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
      .addr (addr), .wdata (wdata), .rdata (rdata),
      .evt_half (evt_half), .evt_pkg (evt_pkg), .evt_queue (evt_queue),
      .ch_busy (ch_busy), .irq (irq)
   );

   // {channel[4], event kind[2], enable word0[32], enable word1[32], expected irq[1]}
   localparam int NVEC = 8;
   localparam logic [70:0] VEC [NVEC] = '{
      {4'd0,  2'd0, 32'h0000_0001, 32'h0000_0000, 1'b1},
      {4'd0,  2'd1, 32'h0000_0001, 32'h0000_0000, 1'b0},
      {4'd7,  2'd2, 32'h4000_0000, 32'h0000_0000, 1'b1},
      {4'd8,  2'd2, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},
      {4'd15, 2'd1, 32'h0000_0000, 32'h2000_0000, 1'b1},
      {4'd9,  2'd0, 32'h0000_0000, 32'h0000_0010, 1'b1},
      {4'd9,  2'd0, 32'h0000_0000, 32'h0000_0020, 1'b0},
      {4'd3,  2'd1, 32'h0000_2000, 32'h0000_0000, 1'b1}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic pulse(input int ch, input int kind);
      case (kind)
         0: evt_half[ch]  = 1'b1;
         1: evt_pkg[ch]   = 1'b1;
         default: evt_queue[ch] = 1'b1;
      endcase
      @(negedge clk);
      evt_half = '0; evt_pkg = '0; evt_queue = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 irq", {31'b0, irq}, 32'h0);
      check("R1 rdata", rdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(8'h00, v); check("R1 en0", v, 32'h0);
      rd(8'h04, v); check("R1 en1", v, 32'h0);
      rd(8'h10, v); check("R1 pend0", v, 32'h0);
      rd(8'h14, v); check("R1 pend1", v, 32'h0);

      // table walk: R2 R3 R4 R7
      for (int i = 0; i < NVEC; i++) begin
         logic [3:0]  ch;
         logic [1:0]  kind;
         logic [31:0] e0, e1, expbit;
         logic        eirq;
         {ch, kind, e0, e1, eirq} = VEC[i];
         wr(8'h10, 32'hFFFF_FFFF);
         wr(8'h14, 32'hFFFF_FFFF);
         wr(8'h00, e0);
         wr(8'h04, e1);
         pulse(int'(ch), int'(kind));
         check("R7 irq", {31'b0, irq}, {31'b0, eirq});
         expbit = 32'h1 << (4 * (ch % 8) + kind);
         rd((ch < 8) ? 8'h10 : 8'h14, v);
         check("R4 pend", v, expbit);
         rd(8'h00, v); check("R2 R3 en0 readback", v, e0 & 32'h7777_7777);
         rd(8'h04, v); check("R2 R3 en1 readback", v, e1 & 32'h7777_7777);
      end

      // R3: all events on all channels leave reserved bits clear
      wr(8'h10, 32'hFFFF_FFFF);
      wr(8'h14, 32'hFFFF_FFFF);
      evt_half = 16'hFFFF; evt_pkg = 16'hFFFF; evt_queue = 16'hFFFF;
      @(negedge clk);
      evt_half = '0; evt_pkg = '0; evt_queue = '0;
      rd(8'h10, v); check("R3 pend0 reserved", v, 32'h7777_7777);
      rd(8'h14, v); check("R3 pend1 reserved", v, 32'h7777_7777);

      // R5 exact write-one-to-clear
      wr(8'h10, 32'hFFFF_FFFF);
      wr(8'h14, 32'hFFFF_FFFF);
      pulse(0, 0); pulse(0, 1); pulse(0, 2);
      wr(8'h10, 32'h0000_0002);
      rd(8'h10, v); check("R5 partial clear", v, 32'h0000_0005);

      // R6 event beats clear in the same cycle
      pulse(2, 1);
      wr_en = 1'b1; addr = 8'h10; wdata = 32'h0000_0205; evt_pkg[2] = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0; evt_pkg = '0;
      rd(8'h10, v); check("R6 set wins", v, 32'h0000_0200);

      // R8 masked off entirely, then R7 level behaviour
      wr(8'h00, 32'h0);
      wr(8'h04, 32'h0);
      pulse(12, 2);
      check("R8 irq masked", {31'b0, irq}, 32'h0);
      wr(8'h04, 32'h0004_0000);
      check("R7 irq on enable", {31'b0, irq}, 32'h1);
      repeat (3) @(negedge clk);
      check("R7 irq level holds", {31'b0, irq}, 32'h1);
      wr(8'h14, 32'h0004_0000);
      check("R7 irq drops after clear", {31'b0, irq}, 32'h0);

      // R9 global busy word, read-only
      ch_busy = 16'hA5C3;
      rd(8'h30, v); check("R9 busy read", v, 32'h0000_A5C3);
      wr(8'h00, 32'h0000_0011);
      wr(8'h30, 32'hFFFF_FFFF);
      rd(8'h00, v); check("R9 write ignored en0", v, 32'h0000_0011);
      rd(8'h30, v); check("R9 busy unchanged", v, 32'h0000_A5C3);

      // R10 unmapped offsets
      rd(8'h08, v); check("R10 unmapped 08", v, 32'h0);
      rd(8'h20, v); check("R10 unmapped 20", v, 32'h0);

      // R10 latency and R11 hold
      rd(8'h30, v);
      ch_busy = 16'h0F0F;
      addr = 8'h30;
      @(negedge clk);
      check("R11 hold without strobe", rdata, 32'h0000_A5C3);
      rd_en = 1'b1;
      check("R10 not before edge", rdata, 32'h0000_A5C3);
      @(negedge clk);
      rd_en = 1'b0;
      check("R10 after edge", rdata, 32'h0000_0F0F);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule